// File: doc/BRIEF.md
# Clock Controller Bring-Up Sequencer

This block replaces boot firmware for the first clock setup of a chip. After a `start` pulse it acts as the only master on a simple 32-bit request/acknowledge register bus toward a clock and reset controller. It runs a fixed list of steps in a fixed order.

First it moves the core clock onto the reference oscillator. It then reprograms the core PLL dividers and polls until the PLL reports lock, and only then returns the core clock to the PLL. Next it writes the device reset register to zero, which holds the memory and network blocks in reset. For the DDR PLL it gates the output, reprograms the dividers, waits for lock and ungates the output again.

Every change to a register is a read followed by a write, so all bits outside the touched fields keep their old values. The one exception is the reset register, which is written whole.

Each lock poll is bounded by a cycle budget given on `lock_timeout`. If the budget runs out, the sequencer stops where it is, raises a sticky error and reports the index of the step it had reached.

Step indices: 0 select reference clock, 1 core PLL program, 2 core PLL lock wait, 3 select PLL clock, 4 device reset write, 5 DDR output gate, 6 DDR PLL program, 7 DDR PLL lock wait, 8 DDR output ungate.

Top module: `pll_boot_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, `bus_req`, `busy`, `done` and `tmo_err` are 0 and `err_step` is 0.
- R2: A `start` pulse while idle launches the sequence. The first access is a read of byte offset 0x24, then a write there of the read value with bit 0 forced to 1.
- R3: Offset 0x04 is next read and rewritten. In the write, bits 5:0=0, 14:6=59, 17:15=2, 20:18=4 and bit 24=0. Every other bit keeps the read value.
- R4: The sequencer then reads 0x04 repeatedly. It issues no other access until a read returns bit 31 set.
- R5: After core lock, 0x24 is read and rewritten with bit 0 cleared and other bits kept. Then 0x28 is written with 0, with no read before it.
- R6: The DDR steps come next, in this order. First 0x10 is read and rewritten with bit 31 cleared. Then 0x0C is read and rewritten with the R3 field layout holding 0, 59, 5, 4 and bit 24=0. Then 0x0C is polled until bit 31 is set. Last, 0x10 is read and rewritten with bit 31 set. After that `done` rises.
- R7: `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until the cycle in which `bus_ack` is high. Only one access is outstanding at a time.
- R8: A poll read that returns bit 31 clear, once at least `lock_timeout` cycles have passed in that poll step, ends the sequence. `tmo_err` then rises and stays high until the next `start`, `err_step` shows 2 (core) or 7 (DDR), and no further access is issued. A read that returns lock always wins, even with `lock_timeout` = 0.
- R9: `start` while `busy` is ignored. `done` and `tmo_err` are never high together, and `done` stays high until the next `start`, which clears both flags and runs the sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch pulse |
| lock_timeout | input | TMO_W | Cycle budget for each lock poll step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held until next start |
| tmo_err | output | 1 | Sticky lock timeout error |
| err_step | output | 4 | Step index at which the timeout hit |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Byte offset of the controller register |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access accepted and complete |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The bench builds the block with `TMO_W` = 10 and the default 8-bit address. With that width, timeouts of 0 and 30 cycles are legal values, so both expiry steps and the lock-on-first-read corner case can be reached in a few hundred cycles. The bench's controller model takes a lock delay per PLL and a variable acknowledge latency. These settings drive the sequence through fast and slow handshakes, through a lock that never comes on either PLL, and through a restart after an error.

// File: rtl/pll_boot_pkg.sv
package pll_boot_pkg;

    localparam int REG_W     = 32;
    localparam int STEP_W    = 4;
    localparam int NUM_STEPS = 9;
    localparam int LOCK_BIT  = 31;

    // controller register byte offsets used by the sequence
    localparam logic [7:0] OFS_CORE_CFG = 8'h04;
    localparam logic [7:0] OFS_DDR_CFG0 = 8'h0C;
    localparam logic [7:0] OFS_DDR_CFG1 = 8'h10;
    localparam logic [7:0] OFS_CLK_SEL  = 8'h24;
    localparam logic [7:0] OFS_DEV_RST  = 8'h28;

    // PLL config word: dividers, range and bypass (bit 24) in the low bits
    function automatic logic [REG_W-1:0] pll_word(input int unsigned r, f, q, rg);
        return {7'd0, 1'b0, 3'd0, 3'(rg), 3'(q), 9'(f), 6'(r)};
    endfunction

    localparam logic [REG_W-1:0] PLL_FIELD_MASK = 32'h011F_FFFF;
    localparam logic [REG_W-1:0] CORE_PLL_SET   = pll_word(0, 59, 2, 4);
    localparam logic [REG_W-1:0] DDR_PLL_SET    = pll_word(0, 59, 5, 4);
    localparam logic [REG_W-1:0] OUT_GATE_BIT   = 32'h8000_0000;
    localparam logic [REG_W-1:0] REF_SEL_BIT    = 32'h0000_0001;

    typedef enum logic [1:0] {K_RMW, K_WRITE, K_POLL} step_kind_e;
    typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE, PH_POLL} phase_e;

    typedef struct packed {
        step_kind_e       kind;
        logic [7:0]       ofs;
        logic [REG_W-1:0] clr;
        logic [REG_W-1:0] set;
    } step_t;

    function automatic step_t step_info(input logic [STEP_W-1:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = '{K_RMW,   OFS_CLK_SEL,  REF_SEL_BIT,    REF_SEL_BIT};
            4'd1:    s = '{K_RMW,   OFS_CORE_CFG, PLL_FIELD_MASK, CORE_PLL_SET};
            4'd2:    s = '{K_POLL,  OFS_CORE_CFG, '0,             '0};
            4'd3:    s = '{K_RMW,   OFS_CLK_SEL,  REF_SEL_BIT,    '0};
            4'd4:    s = '{K_WRITE, OFS_DEV_RST,  '1,             '0};
            4'd5:    s = '{K_RMW,   OFS_DDR_CFG1, OUT_GATE_BIT,   '0};
            4'd6:    s = '{K_RMW,   OFS_DDR_CFG0, PLL_FIELD_MASK, DDR_PLL_SET};
            4'd7:    s = '{K_POLL,  OFS_DDR_CFG0, '0,             '0};
            4'd8:    s = '{K_RMW,   OFS_DDR_CFG1, OUT_GATE_BIT,   OUT_GATE_BIT};
            default: s = '{K_POLL,  8'h00,        '0,             '0};
        endcase
        return s;
    endfunction

    function automatic phase_e kind_phase(input step_kind_e k);
        case (k)
            K_RMW:   return PH_READ;
            K_WRITE: return PH_WRITE;
            default: return PH_POLL;
        endcase
    endfunction

endpackage

// File: rtl/seq_bus_port.sv
module seq_bus_port
    import pll_boot_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic              cmd_we,
    input  logic [7:0]        cmd_ofs,
    input  logic [REG_W-1:0]  cmd_wdata,
    output logic              rsp_vld,
    output logic [REG_W-1:0]  rsp_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic [REG_W-1:0]  bus_rdata
);

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  wdata;
        logic              rvld;
        logic [REG_W-1:0]  rdata;
    } port_t;

    port_t q, d;

    always_comb begin
        d      = q;
        d.rvld = 1'b0;
        if (q.req && bus_ack) begin
            d.req   = 1'b0;
            d.rvld  = 1'b1;
            d.rdata = bus_rdata;
        end else if (!q.req && cmd_go) begin
            d.req   = 1'b1;
            d.we    = cmd_we;
            d.addr  = ADDR_W'(cmd_ofs);
            d.wdata = cmd_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_req   = q.req;
    assign bus_we    = q.we;
    assign bus_addr  = q.addr;
    assign bus_wdata = q.wdata;
    assign rsp_vld   = q.rvld;
    assign rsp_data  = q.rdata;

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_go && (bus_req || rsp_vld)));

endmodule

// File: rtl/seq_lock_timer.sv
module seq_lock_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (clear)               d.cnt = '0;
        else if (q.cnt != CNT_MAX) d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = (q.cnt >= limit);

    assert_cnt_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> q.cnt >= $past(q.cnt));

endmodule

// File: rtl/pll_boot_seq.sv
module pll_boot_seq
    import pll_boot_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TMO_W-1:0]  lock_timeout,
    output logic              busy,
    output logic              done,
    output logic              tmo_err,
    output logic [3:0]        err_step,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
        logic              wait_rsp;
        logic [REG_W-1:0]  hold;
        logic              done;
        logic              err;
        logic [STEP_W-1:0] err_step;
    } ctl_t;

    ctl_t q, d;

    logic             cmd_go, cmd_we, tmr_clear, tmo_expired, rsp_vld, adv;
    logic [7:0]       cmd_ofs;
    logic [REG_W-1:0] cmd_wdata, rsp_data;
    step_t            cur, nxt, first;

    always_comb begin
        d         = q;
        cmd_go    = 1'b0;
        cmd_we    = 1'b0;
        tmr_clear = 1'b0;
        adv       = 1'b0;
        cur       = step_info(q.step);
        nxt       = step_info(q.step + 1'b1);
        first     = step_info('0);
        cmd_ofs   = cur.ofs;
        cmd_wdata = q.hold;

        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.done     = 1'b0;
                    d.err      = 1'b0;
                    d.err_step = '0;
                    d.step     = '0;
                    d.phase    = kind_phase(first.kind);
                    d.hold     = first.set;
                    d.wait_rsp = 1'b0;
                    tmr_clear  = 1'b1;
                end
            end
            PH_READ: begin
                if (!q.wait_rsp) begin
                    cmd_go     = 1'b1;
                    d.wait_rsp = 1'b1;
                end else if (rsp_vld) begin
                    d.hold     = (rsp_data & ~cur.clr) | cur.set;
                    d.phase    = PH_WRITE;
                    d.wait_rsp = 1'b0;
                end
            end
            PH_WRITE: begin
                if (!q.wait_rsp) begin
                    cmd_go     = 1'b1;
                    cmd_we     = 1'b1;
                    d.wait_rsp = 1'b1;
                end else if (rsp_vld) begin
                    adv = 1'b1;
                end
            end
            PH_POLL: begin
                if (!q.wait_rsp) begin
                    cmd_go     = 1'b1;
                    d.wait_rsp = 1'b1;
                end else if (rsp_vld) begin
                    if (rsp_data[LOCK_BIT]) begin
                        adv = 1'b1;
                    end else if (tmo_expired) begin
                        d.phase    = PH_IDLE;
                        d.err      = 1'b1;
                        d.err_step = q.step;
                        d.wait_rsp = 1'b0;
                    end else begin
                        d.wait_rsp = 1'b0;
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase

        if (adv) begin
            d.wait_rsp = 1'b0;
            if (q.step == LAST_STEP) begin
                d.phase = PH_IDLE;
                d.done  = 1'b1;
            end else begin
                d.step    = q.step + 1'b1;
                d.phase   = kind_phase(nxt.kind);
                d.hold    = nxt.set;
                tmr_clear = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{phase: PH_IDLE, default: '0};
        else        q <= d;
    end

    seq_bus_port #(.ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_go    (cmd_go),
        .cmd_we    (cmd_we),
        .cmd_ofs   (cmd_ofs),
        .cmd_wdata (cmd_wdata),
        .rsp_vld   (rsp_vld),
        .rsp_data  (rsp_data),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    seq_lock_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .limit   (lock_timeout),
        .expired (tmo_expired)
    );

    assign busy     = (q.phase != PH_IDLE);
    assign done     = q.done;
    assign tmo_err  = q.err;
    assign err_step = 4'(q.err_step);

    assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && tmo_err));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !bus_req);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err && !start |=> tmo_err && !bus_req);

    assert_core_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == ADDR_W'(OFS_CORE_CFG)
            |-> (bus_wdata & PLL_FIELD_MASK) == CORE_PLL_SET);

    assert_ddr_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == ADDR_W'(OFS_DDR_CFG0)
            |-> (bus_wdata & PLL_FIELD_MASK) == DDR_PLL_SET);

    assert_rst_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == ADDR_W'(OFS_DEV_RST) |-> bus_wdata == '0);

endmodule

// File: tb/tb_pll_boot_seq.sv
module tb_pll_boot_seq;

    localparam int TMO_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [TMO_W-1:0] lock_timeout = '0;
    logic        busy, done, tmo_err, bus_req, bus_we;
    logic [3:0]  err_step;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #10 clk = ~clk;

    pll_boot_seq #(.ADDR_W(8), .TMO_W(TMO_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lock_timeout(lock_timeout),
        .busy(busy), .done(done), .tmo_err(tmo_err), .err_step(err_step),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // controller model
    logic [31:0] regs [16];
    logic [31:0] init_regs [16];
    int ack_delay, core_delay, ddr_delay;
    int core_cnt, ddr_cnt, polls_core, polls_ddr, txn_cnt;
    logic [31:0] last_rd;

    // expected access list: kind 0 read, 1 rmw write, 2 poll, 3 plain write
    int          exp_kind [15];
    logic [7:0]  exp_addr [15];
    logic [31:0] exp_clr  [15];
    logic [31:0] exp_set  [15];
    string       exp_req  [15];
    int          exp_ptr;

    localparam logic [31:0] FMASK = 32'h011F_FFFF;
    localparam logic [31:0] CORE_V = 32'h0011_0EC0;
    localparam logic [31:0] DDR_V  = 32'h0012_8EC0;

    task automatic set_exp(input int i, input int k, input logic [7:0] a,
                           input logic [31:0] c, input logic [31:0] s, input string r);
        exp_kind[i] = k; exp_addr[i] = a; exp_clr[i] = c; exp_set[i] = s; exp_req[i] = r;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic load_regs(input int seed);
        for (int i = 0; i < 16; i++) begin
            regs[i] = (32'h9E37_79B9 * (i + seed * 7)) ^ 32'h5A5A_0F0F;
            init_regs[i] = regs[i];
        end
        core_cnt = 0; ddr_cnt = 0; polls_core = 0; polls_ddr = 0;
    endtask

    // one accepted access: compare with the expected list, update the model
    task automatic do_txn(output logic [31:0] rd);
        int i;
        logic [31:0] ew;
        rd = '0;
        txn_cnt++;
        i = exp_ptr;
        if (i >= 15) begin
            chk(0, "R9", "access after sequence end", {24'd0, bus_addr}, 32'd0);
            return;
        end
        chk(bus_addr == exp_addr[i], exp_req[i], "address", {24'd0, bus_addr}, {24'd0, exp_addr[i]});
        chk(bus_we == (exp_kind[i] == 1 || exp_kind[i] == 3), exp_req[i], "direction",
            {31'd0, bus_we}, {31'd0, exp_kind[i] == 1 || exp_kind[i] == 3});
        if (bus_we) begin
            ew = (exp_kind[i] == 3) ? 32'd0 : ((last_rd & ~exp_clr[i]) | exp_set[i]);
            chk(bus_wdata == ew, exp_req[i], "write data", bus_wdata, ew);
            regs[bus_addr[5:2]] = bus_wdata;
            if (bus_addr == 8'h04) begin regs[1] = bus_wdata & 32'h7FFF_FFFF; core_cnt = 0; end
            if (bus_addr == 8'h0C) begin regs[3] = bus_wdata & 32'h7FFF_FFFF; ddr_cnt = 0; end
            exp_ptr++;
        end else begin
            rd = regs[bus_addr[5:2]];
            if (bus_addr == 8'h04) begin if (core_cnt >= core_delay) rd[31] = 1'b1; core_cnt++; end
            if (bus_addr == 8'h0C) begin if (ddr_cnt >= ddr_delay) rd[31] = 1'b1; ddr_cnt++; end
            last_rd = rd;
            if (exp_kind[i] == 2) begin
                if (bus_addr == 8'h04) polls_core++; else polls_ddr++;
                if (rd[31]) exp_ptr++;
            end else begin
                exp_ptr++;
            end
        end
    endtask

    // responder: acknowledges after ack_delay idle cycles
    initial begin
        int waitc = 0;
        logic [31:0] rd;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (waitc < ack_delay) waitc++;
                else begin
                    do_txn(rd);
                    bus_rdata = rd;
                    bus_ack = 1'b1;
                    waitc = 0;
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run(input int ackd, input int cd, input int dd, input int tmo,
                       input int exp_err, input bit poke);
        int t;
        ack_delay = ackd; core_delay = cd; ddr_delay = dd;
        lock_timeout = TMO_W'(tmo);
        exp_ptr = 0;
        pulse_start();
        chk(busy && !done && !tmo_err, "R9", "start launches and clears flags",
            {29'd0, busy, done, tmo_err}, 32'h4);
        if (poke) begin
            repeat (8) @(negedge clk);
            pulse_start();
            chk(busy && !done, "R9", "start while busy keeps running", {30'd0, busy, done}, 32'h2);
        end
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        if (exp_err < 0) begin
            chk(done && !tmo_err, "R6", "sequence completes", {30'd0, done, tmo_err}, 32'h2);
            chk(exp_ptr == 15, "R6", "all steps seen", 32'(exp_ptr), 32'd15);
            chk(polls_core == cd + 1, "R4", "core poll reads", 32'(polls_core), 32'(cd + 1));
            chk(polls_ddr == dd + 1, "R6", "ddr poll reads", 32'(polls_ddr), 32'(dd + 1));
            chk(regs[9] == (init_regs[9] & ~32'h1), "R5", "clock select final", regs[9], init_regs[9] & ~32'h1);
            chk(regs[10] == 32'd0, "R5", "device reset final", regs[10], 32'd0);
            chk(regs[4] == (init_regs[4] | 32'h8000_0000), "R6", "ddr output enabled", regs[4], init_regs[4] | 32'h8000_0000);
            chk((regs[1] & FMASK) == CORE_V, "R3", "core fields", regs[1] & FMASK, CORE_V);
            chk((regs[1] & ~FMASK & 32'h7FFF_FFFF) == (init_regs[1] & ~FMASK & 32'h7FFF_FFFF),
                "R3", "core other bits kept", regs[1], init_regs[1]);
            chk((regs[3] & ~FMASK & 32'h7FFF_FFFF) == (init_regs[3] & ~FMASK & 32'h7FFF_FFFF),
                "R6", "ddr other bits kept", regs[3], init_regs[3]);
            repeat (6) @(negedge clk);
            chk(done && !busy && !bus_req, "R9", "done holds", {30'd0, done, busy}, 32'h2);
        end else begin
            chk(tmo_err && !done, "R8", "timeout flagged", {30'd0, tmo_err, done}, 32'h2);
            chk(err_step == 4'(exp_err), "R8", "error step", {28'd0, err_step}, 32'(exp_err));
            chk(exp_ptr == (exp_err == 2 ? 4 : 12), "R4", "halted in poll", 32'(exp_ptr),
                (exp_err == 2) ? 32'd4 : 32'd12);
            t = txn_cnt;
            repeat (12) @(negedge clk);
            chk(txn_cnt == t && tmo_err && !bus_req && !busy, "R8", "quiet and sticky",
                32'(txn_cnt), 32'(t));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        txn_cnt = 0; last_rd = '0; ack_delay = 0; core_delay = 0; ddr_delay = 0; exp_ptr = 0;
        set_exp(0, 0, 8'h24, 0, 0, "R2");
        set_exp(1, 1, 8'h24, 32'h1, 32'h1, "R2");
        set_exp(2, 0, 8'h04, 0, 0, "R3");
        set_exp(3, 1, 8'h04, FMASK, CORE_V, "R3");
        set_exp(4, 2, 8'h04, 0, 0, "R4");
        set_exp(5, 0, 8'h24, 0, 0, "R5");
        set_exp(6, 1, 8'h24, 32'h1, 32'h0, "R5");
        set_exp(7, 3, 8'h28, 0, 0, "R5");
        set_exp(8, 0, 8'h10, 0, 0, "R6");
        set_exp(9, 1, 8'h10, 32'h8000_0000, 32'h0, "R6");
        set_exp(10, 0, 8'h0C, 0, 0, "R6");
        set_exp(11, 1, 8'h0C, FMASK, DDR_V, "R6");
        set_exp(12, 2, 8'h0C, 0, 0, "R6");
        set_exp(13, 0, 8'h10, 0, 0, "R6");
        set_exp(14, 1, 8'h10, 32'h8000_0000, 32'h8000_0000, "R6");
        load_regs(1);

        repeat (4) @(negedge clk);
        chk(!bus_req && !busy && !done && !tmo_err && err_step == 0, "R1", "state in reset",
            {27'd0, bus_req, busy, done, tmo_err, |err_step}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_req && !busy && !done && !tmo_err, "R1", "idle after reset",
            {28'd0, bus_req, busy, done, tmo_err}, 32'd0);

        // R7 handshake at zero latency, R9 start while busy
        load_regs(1); run(0, 3, 3, 200, -1, 1);
        // R8 corner: zero budget but lock on first read, slow acknowledge
        load_regs(2); run(2, 0, 0, 0, -1, 0);
        // R8 core lock never arrives
        load_regs(3); run(1, 1000000, 0, 30, 2, 0);
        // R8 DDR lock never arrives, zero budget: one poll read only
        load_regs(4); run(0, 0, 1000000, 0, 7, 0);
        chk(polls_ddr == 1, "R8", "single ddr poll at zero budget", 32'(polls_ddr), 32'd1);
        // R9 restart after error
        load_regs(5); run(1, 2, 5, 100, -1, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule